// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing controller of a 256-byte nonvolatile store that sits on a two-wire I2C bus as a slave. A register array stands in for the storage cells, and a cycle counter stands in for the program pulse. The block cleans both bus lines with a glitch filter and finds start and stop conditions. It compares the device byte against its own address, takes an 8-bit word address, and then either collects write data or streams stored bytes back to the master.

Written bytes go into a 16-entry page latch. They reach the array only when the stop condition closes the write. The block then refuses its own address until the program time has run out, so a master can poll it for completion. After reset it also stays silent for a hold-off period. A write that closes while the supply-low inhibit input is high is thrown away. The pad is open drain: the block only ever requests that SDA be pulled low.

Top module: `serialMemSlave`

## Requirements
- R1: After reset the SDA pull-down request `sdaOe` is 0, and it stays 0 whenever the block is neither acknowledging nor returning a 0 data bit.
- R2: For the first HOLD_CYCLES clock cycles after reset no byte is acknowledged, whatever the bus carries.
- R3: A device byte is acknowledged only when its bits 7:4 equal 1010 and its bits 3:1 equal DEV_SEL. Bit 0 selects read (1) or write (0). After a device byte that does not match, the bus is ignored until the next start.
- R4: A write transfer sends the device byte, the word address byte, then data bytes. The block acknowledges every byte, and a single data byte lands at the word address once the stop is seen.
- R5: Consecutive data bytes go to consecutive addresses, but only the low 4 address bits advance, so they wrap inside the 16-byte page. A later byte overwrites an earlier one at the same location. Nothing reaches the array before the stop.
- R6: For PROG_CYCLES cycles after a committed write, the device byte is not acknowledged.
- R7: A write whose stop arrives while `supplyLow` is 1 leaves the array unchanged and starts no busy period.
- R8: A random read (a write of device byte and word address, then a repeated start and a read device byte) returns the byte at that address. A read with no word address continues from the internal address pointer.
- R9: In a read, each master acknowledge advances the pointer by one, rolling over from 255 to 0. A master non-acknowledge ends the transfer with SDA released.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles has no effect on the transfer.
- R11: After reset every array location reads 0xFF.
- R12: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus is oversampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| supplyLow | input | 1 | Supply-low inhibit; 1 blocks committing a write |
| sdaOe | output | 1 | 1 requests the open-drain pad to pull SDA low |

## Verification
The bench builds the block with FILT_LEN of 3, HOLD_CYCLES of 400 and PROG_CYCLES of 600. With these values a single device byte sent right after reset falls inside the hold-off. A poll sent right after a stop lands inside the busy period. A two-cycle pulse on either line falls just under the filter threshold. The 256-byte array and 16-byte page keep their full sizes, so page wrap, overwrite and the 255-to-0 rollover are all exercised on the real address space.

// File: rtl/serialMemPkg.sv
`timescale 1ns / 1ps
package serialMemPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WORD,
    S_WRITE,
    S_READ,
    S_SKIP
  } busState_t;

  // Strobes from the bus control to the storage datapath, at most one per cycle.
  typedef struct packed {
    logic setAddr;    // word address byte received
    logic putByte;    // write data byte received into the page latch
    logic fetchByte;  // load next read byte and advance the pointer
    logic commit;     // stop closed a write sequence with latched data
  } memStrobe_t;

endpackage

// File: rtl/busFilter.sv
`timescale 1ns / 1ps
module busFilter #(
  parameter int FILT_LEN = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runLen;

  // Two-flop synchroniser, then the level must differ for FILT_LEN cycles to pass.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      cleanOut <= 1'b1;
      runLen   <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runLen <= '0;
      end else if (runLen == CW'(FILT_LEN - 1)) begin
        cleanOut <= syncQ[1];
        runLen   <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/memSlaveCtrl.sv
`timescale 1ns / 1ps
module memSlaveCtrl
  import serialMemPkg::*;
#(
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclClean,
  input  logic       sdaClean,
  input  logic       ready,
  input  logic       latchUsed,
  input  logic [7:0] rdData,
  input  logic [7:0] txByte,
  output logic [7:0] rxByte,
  output logic       sdaOe,
  output memStrobe_t strb
);
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  busState_t  state;
  logic       sclQ, sdaQ;
  logic       sclRise, sclFall, startSeen, stopSeen;
  logic [3:0] bitCnt;
  logic       rdMode, masterAck, devHit;
  logic [2:0] bitSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclClean;
      sdaQ <= sdaClean;
    end
  end

  assign sclRise   = sclClean & ~sclQ;
  assign sclFall   = ~sclClean & sclQ;
  assign startSeen = sclQ & sclClean & sdaQ & ~sdaClean;
  assign stopSeen  = sclQ & sclClean & ~sdaQ & sdaClean;
  assign devHit    = (rxByte[7:1] == {DEV_TYPE, DEV_SEL}) && ready;
  assign bitSel    = 3'd7 - bitCnt[2:0];

  always_comb begin
    strb           = '0;
    strb.setAddr   = sclFall && (bitCnt == LAST_BIT) && (state == S_WORD);
    strb.putByte   = sclFall && (bitCnt == LAST_BIT) && (state == S_WRITE);
    strb.fetchByte = sclFall && (bitCnt == ACK_SLOT) &&
                     (((state == S_DEV) && rdMode) || ((state == S_READ) && masterAck));
    strb.commit    = stopSeen && (state == S_WRITE) && latchUsed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      rxByte    <= '0;
      sdaOe     <= 1'b0;
      rdMode    <= 1'b0;
      masterAck <= 1'b0;
    end else if (startSeen) begin
      state  <= S_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopSeen) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (state != S_IDLE && state != S_SKIP) begin
      if (sclRise) begin
        if (bitCnt < LAST_BIT) rxByte <= {rxByte[6:0], sdaClean};
        if (bitCnt == LAST_BIT && state == S_READ) masterAck <= ~sdaClean;
        if (bitCnt != ACK_SLOT) bitCnt <= bitCnt + 4'd1;
      end else if (sclFall) begin
        if (bitCnt == LAST_BIT) begin
          // byte done: acknowledge it, or release for the master's answer
          if (state == S_READ) begin
            sdaOe <= 1'b0;
          end else if (state == S_DEV) begin
            if (devHit) begin
              sdaOe  <= 1'b1;
              rdMode <= rxByte[0];
            end else begin
              state <= S_SKIP;
            end
          end else begin
            sdaOe <= 1'b1;
          end
        end else if (bitCnt == ACK_SLOT) begin
          bitCnt <= '0;
          case (state)
            S_DEV: begin
              if (rdMode) begin
                state <= S_READ;
                sdaOe <= ~rdData[7];
              end else begin
                state <= S_WORD;
                sdaOe <= 1'b0;
              end
            end
            S_WORD: begin
              state <= S_WRITE;
              sdaOe <= 1'b0;
            end
            S_READ: begin
              if (masterAck) begin
                sdaOe <= ~rdData[7];
              end else begin
                state <= S_SKIP;
                sdaOe <= 1'b0;
              end
            end
            default: sdaOe <= 1'b0;
          endcase
        end else if (state == S_READ) begin
          sdaOe <= ~txByte[bitSel];
        end
      end
    end
  end
endmodule

// File: rtl/memSlaveData.sv
`timescale 1ns / 1ps
module memSlaveData
  import serialMemPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int HOLD_CYCLES = 27_000_000,
  parameter int PROG_CYCLES = 500_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyLow,
  input  memStrobe_t strb,
  input  logic [7:0] rxByte,
  output logic [7:0] rdData,
  output logic [7:0] txByte,
  output logic       ready,
  output logic       busy,
  output logic       latchUsed
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HW    = $clog2(HOLD_CYCLES + 1);
  localparam int PW    = $clog2(PROG_CYCLES + 1);

  logic [7:0]        memArr  [DEPTH];
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   pageVld;
  logic [ADDR_W-1:0] addrPtr;
  logic [PAGE_W-1:0] pageOff;
  logic [HW-1:0]     holdCnt;
  logic [PW-1:0]     progCnt;
  logic              doProgram;

  assign pageOff   = addrPtr[PAGE_W-1:0];
  assign rdData    = memArr[addrPtr];
  assign latchUsed = |pageVld;
  assign doProgram = strb.commit && !supplyLow;
  assign busy      = (progCnt != '0);
  assign ready     = (holdCnt == HW'(HOLD_CYCLES)) && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPtr <= '0;
      pageVld <= '0;
      txByte  <= '0;
    end else if (strb.setAddr) begin
      addrPtr <= rxByte[ADDR_W-1:0];
      pageVld <= '0;
    end else if (strb.putByte) begin
      pageVld[pageOff] <= 1'b1;
      addrPtr          <= {addrPtr[ADDR_W-1:PAGE_W], pageOff + 1'b1};
    end else if (strb.fetchByte) begin
      txByte  <= rdData;
      addrPtr <= addrPtr + 1'b1;
    end else if (strb.commit) begin
      pageVld <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.putByte) pageBuf[pageOff] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) memArr[a] <= 8'hFF;
    end else if (doProgram) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pageVld[i]) memArr[{addrPtr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      progCnt <= '0;
    end else begin
      if (holdCnt != HW'(HOLD_CYCLES)) holdCnt <= holdCnt + 1'b1;
      if (doProgram)           progCnt <= PW'(PROG_CYCLES);
      else if (progCnt != '0)  progCnt <= progCnt - 1'b1;
    end
  end
endmodule

// File: rtl/serialMemSlave.sv
`timescale 1ns / 1ps
module serialMemSlave
  import serialMemPkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         FILT_LEN    = 10,
  parameter int         HOLD_CYCLES = 27_000_000,
  parameter int         PROG_CYCLES = 500_000,
  parameter logic [2:0] DEV_SEL     = 3'b000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic supplyLow,
  output logic sdaOe
);
  logic [1:0] rawLines, cleanLines;
  logic       ready, busy, latchUsed;
  logic [7:0] rdData, txByte, rxByte;
  memStrobe_t strb;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    busFilter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawLines[g]),
      .cleanOut(cleanLines[g])
    );
  end

  memSlaveCtrl #(.DEV_SEL(DEV_SEL)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclClean (cleanLines[0]),
    .sdaClean (cleanLines[1]),
    .ready    (ready),
    .latchUsed(latchUsed),
    .rdData   (rdData),
    .txByte   (txByte),
    .rxByte   (rxByte),
    .sdaOe    (sdaOe),
    .strb     (strb)
  );

  memSlaveData #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .HOLD_CYCLES(HOLD_CYCLES),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .supplyLow(supplyLow),
    .strb     (strb),
    .rxByte   (rxByte),
    .rdData   (rdData),
    .txByte   (txByte),
    .ready    (ready),
    .busy     (busy),
    .latchUsed(latchUsed)
  );
endmodule

// File: rtl/serialMemChecker.sv
`timescale 1ns / 1ps
module serialMemChecker
  import serialMemPkg::*;
#(
  parameter int HOLD_CYCLES = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       supplyLow,
  input logic       busy,
  input memStrobe_t strb
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  logic [HW-1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != HW'(HOLD_CYCLES)) sinceRst <= sinceRst + 1'b1;
  end

  a_r2_holdoff_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < HW'(HOLD_CYCLES)) |-> !sdaOe);

  a_r12_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  a_r7_inhibit_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && supplyLow) |=> !busy);

  a_r4_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setAddr, strb.putByte, strb.fetchByte, strb.commit}));
endmodule

bind serialMemSlave serialMemChecker #(.HOLD_CYCLES(HOLD_CYCLES)) u_serialMemChk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaOe    (sdaOe),
  .supplyLow(supplyLow),
  .busy     (busy),
  .strb     (strb)
);

// File: tb/tb_serialMemSlave.sv
`timescale 1ns / 1ps
module tb_serialMemSlave;
  localparam int FILT = 3;
  localparam int HOLD = 400;
  localparam int PROG = 600;
  localparam int Q    = 8;
  localparam int GL   = FILT - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1, supplyLow = 1'b0;
  logic sdaOe, sdaLine;
  bit   glitchOn = 1'b0;
  bit   finished = 1'b0;
  int   total = 0, bad = 0;
  int   r12Bad = 0, r2Bad = 0, sinceRst = 0;
  logic prevScl = 1'b1, prevOe = 1'b0;
  int   expMem[256];
  int   expPtr = 0;
  logic [7:0] wq[$];

  always #2 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;

  serialMemSlave #(
    .ADDR_W(8), .PAGE_W(4), .FILT_LEN(FILT),
    .HOLD_CYCLES(HOLD), .PROG_CYCLES(PROG), .DEV_SEL(3'b000)
  ) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .supplyLow(supplyLow), .sdaOe(sdaOe)
  );

  // Per-clock reference checks, sampled 1 ns after the edge.
  always begin
    @(posedge clk);
    #1;
    if (rstN) begin
      sinceRst++;
      if (sclDrv && prevScl && (sdaOe !== prevOe)) begin
        r12Bad++;
        if (r12Bad < 5) $display("FAIL R12 sdaOe moved with SCL high act=%0b exp=%0b", sdaOe, prevOe);
      end
      if (sinceRst <= HOLD && sdaOe !== 1'b0) begin
        r2Bad++;
        if (r2Bad < 5) $display("FAIL R2 pull-down inside hold-off act=%0b exp=0", sdaOe);
      end
    end
    prevScl = sclDrv;
    prevOe  = sdaOe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitCyc(Q);
    sclDrv = 1'b1; waitCyc(Q);
    sdaDrv = 1'b0; waitCyc(Q);
    sclDrv = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitCyc(Q);
    sclDrv = 1'b1; waitCyc(Q);
    sdaDrv = 1'b1; waitCyc(Q);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaDrv = b;
    if (glitchOn) begin
      waitCyc(3); sclDrv = 1'b1; waitCyc(GL); sclDrv = 1'b0; waitCyc(Q - 3 - GL);
    end else waitCyc(Q);
    sclDrv = 1'b1;
    if (glitchOn) begin
      waitCyc(2); sdaDrv = ~b; waitCyc(GL); sdaDrv = b; waitCyc(Q - 2 - GL);
    end else waitCyc(Q);
    seen = sdaLine;
    waitCyc(Q);
    sclDrv = 1'b0;
    waitCyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic s;
    bit   g;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    g = glitchOn;
    glitchOn = 1'b0;
    clockBit(1'b1, s);
    glitchOn = g;
    acked = !s;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      v = {v[6:0], s};
    end
    clockBit(giveAck ? 1'b0 : 1'b1, s);
  endtask

  task automatic writeSeq(input int addr, input string tag);
    bit a;
    int base, off;
    busStart();
    sendByte(8'hA0, a);               chk(a, {tag, " device byte ack"}, a, 1);
    sendByte(addr[7:0], a);           chk(a, {tag, " word address ack"}, a, 1);
    foreach (wq[i]) begin
      sendByte(wq[i], a);             chk(a, {tag, " data ack"}, a, 1);
    end
    busStop();
    base = addr & 8'hF0;
    off  = addr & 8'h0F;
    if (!supplyLow) foreach (wq[i]) expMem[base | ((off + i) & 15)] = wq[i];
    expPtr = base | ((off + wq.size()) & 15);
  endtask

  task automatic readSeq(input int n, input bit setPtr, input int addr, input string tag);
    bit a;
    logic [7:0] v;
    if (setPtr) begin
      busStart();
      sendByte(8'hA0, a);             chk(a, {tag, " dummy write ack"}, a, 1);
      sendByte(addr[7:0], a);         chk(a, {tag, " word address ack"}, a, 1);
      expPtr = addr;
    end
    busStart();
    sendByte(8'hA1, a);               chk(a, {tag, " read device ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, v);
      chk(v == expMem[expPtr][7:0], {tag, " read data"}, v, expMem[expPtr]);
      expPtr = (expPtr + 1) % 256;
    end
    chk(sdaOe == 1'b0, "R9 released after master nack", sdaOe, 0);
    busStop();
  endtask

  task automatic pollDev(input bit expAck, input logic [7:0] dev, input string tag);
    bit a;
    busStart();
    sendByte(dev, a);
    chk(a == expAck, tag, a, expAck);
    busStop();
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) expMem[i] = 8'hFF;
    waitCyc(5);
    chk(sdaOe == 1'b0, "R1 released in reset", sdaOe, 0);
    rstN = 1'b1;
    waitCyc(2);
    chk(sdaOe == 1'b0, "R1 released after reset", sdaOe, 0);

    // R2: device byte inside the hold-off is not acknowledged
    pollDev(1'b0, 8'hA0, "R2 no ack during hold-off");
    waitCyc(HOLD);

    // R3: wrong type nibble, wrong select bits, trailing byte ignored
    busStart();
    sendByte(8'hB0, a); chk(!a, "R3 wrong type nibble", a, 0);
    sendByte(8'h00, a); chk(!a, "R3 bus ignored after mismatch", a, 0);
    busStop();
    pollDev(1'b0, 8'hA2, "R3 wrong select bits");

    // R11: erased content
    readSeq(1, 1'b1, 8'h10, "R11");

    // R4 byte write, R6 busy polling
    wq = {8'hA5};
    writeSeq(8'h20, "R4");
    pollDev(1'b0, 8'hA0, "R6 no ack while programming");
    waitCyc(PROG);
    pollDev(1'b1, 8'hA0, "R6 ack after program time");
    readSeq(1, 1'b1, 8'h20, "R4");

    // R5 page wrap inside the page
    wq = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    writeSeq(8'h3E, "R5");
    waitCyc(PROG);
    readSeq(16, 1'b1, 8'h30, "R5");

    // R5 overflow: 18 bytes, the last two overwrite the first two
    wq.delete();
    for (int i = 0; i < 18; i++) wq.push_back(8'((i * 3) + 1));
    writeSeq(8'h50, "R5");
    waitCyc(PROG);
    readSeq(3, 1'b1, 8'h50, "R5");

    // R8 current-address read continues from the pointer
    readSeq(2, 1'b0, 0, "R8");

    // R9 rollover from 255 to 0
    wq = {8'h9C, 8'hC9};
    writeSeq(8'hFE, "R9");
    waitCyc(PROG);
    readSeq(4, 1'b1, 8'hFE, "R9");

    // R7 write under supply-low inhibit is dropped and starts no busy time
    supplyLow = 1'b1;
    wq = {8'h5A};
    writeSeq(8'h20, "R7");
    supplyLow = 1'b0;
    readSeq(1, 1'b1, 8'h20, "R7");

    // R10 short pulses on both lines during data bits
    wq = {8'hC3, 8'hFF};
    glitchOn = 1'b1;
    writeSeq(8'h60, "R10");
    glitchOn = 1'b0;
    waitCyc(PROG);
    readSeq(2, 1'b1, 8'h60, "R10");

    chk(r12Bad == 0, "R12 per-cycle drive timing", r12Bad, 0);
    chk(r2Bad == 0, "R2 per-cycle hold-off", r2Bad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule